// File: doc/BRIEF.md
# Deferred-Fault Integer Register File

This block holds the integer architectural state of a statically scheduled core. Each register carries a 64-bit value and one extra tag bit that marks the value as poisoned. A speculative load whose memory access faults does not trap. It still delivers its data word, and the destination register is tagged. Results from the simple ALU writeback path take on the tag of their source operands, so a bad value can pass through any chain of arithmetic without raising an error.

A fault is raised only at the points where a bad value could cause harm. These are a store that reads a poisoned address or data register, and a branch whose condition register is poisoned. The check compares the tags held in the register file at the moment of use. The fault can therefore surface any number of cycles after the load, whatever the depth of the pipeline.

The block has two general read ports and one write port. The write port is shared by the load-return path and the ALU writeback path. Consumer checks and read ports see a write made in the same cycle.

Top module: `deferred_fault_regfile`

## Requirements
- R1: During reset and after it, every register reads as value 0 with tag 0, and no fault is reported.
- R2: A load return with its fault flag set writes its data word to the destination and sets that register's tag. The fault output does not rise because of the load.
- R3: An ALU writeback sets the destination tag to the OR of the stored tags of its two source registers, as held in the cycle of the writeback. A load without the fault flag, or an ALU writeback with two clean sources, clears the destination tag.
- R4: Register 0 always reads as value 0 with tag 0. Writes to register 0 from either path are discarded.
- R5: A branch check with a poisoned condition register, or a store check with a poisoned address or data register, raises fault_valid for one cycle, on the clock edge after the check. fault_idx gives the offending register. When several are poisoned, the priority is branch condition, then store address, then store data.
- R6: fault_valid is 0, and fault_idx is 0, in every cycle that does not follow a check that found poison. Poisoned registers that are only read through the read ports, or never read, raise nothing.
- R7: When a read port or a consumer check names the register being written in the same cycle, it sees the new value and the new tag.
- R8: When the load path and the ALU path both write in the same cycle, the load is written and the ALU result is discarded.
- R9: A tag stays set for any number of idle cycles until a non-poisoning write replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 64 | Read port A value |
| rd_a_tag | output | 1 | Read port A poison tag |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 64 | Read port B value |
| rd_b_tag | output | 1 | Read port B poison tag |
| ld_we | input | 1 | Load return writes this cycle |
| ld_dst | input | 5 | Load destination register |
| ld_data | input | 64 | Load return data |
| ld_fault | input | 1 | Load access faulted |
| alu_we | input | 1 | ALU writeback this cycle |
| alu_dst | input | 5 | ALU destination register |
| alu_data | input | 64 | ALU result |
| alu_src_a | input | 5 | First source register of the ALU result |
| alu_src_b | input | 5 | Second source register of the ALU result |
| br_valid | input | 1 | Branch condition check this cycle |
| br_idx | input | 5 | Branch condition register |
| st_valid | input | 1 | Store operand check this cycle |
| st_addr_idx | input | 5 | Store address register |
| st_data_idx | input | 5 | Store data register |
| fault_valid | output | 1 | Deferred fault raised (one-cycle pulse) |
| fault_idx | output | 5 | Register that triggered the fault |

## Verification
Directed sequences come first. A faulting load and a clean load feed ALU chains, which shows whether the tags combine correctly and whether a clean write clears a tag. Checks run on clean and poisoned operands, with several poisoned at once, to separate fault detection from the priority order. A long idle gap before a consumer shows whether the tag persists. Same-cycle write and read and same-cycle load and ALU writes expose bypass and arbitration errors. Register 0 is tried as a target. A long random stream with indices clustered on a few registers then compares every output each cycle against the behavioural model, so many collisions occur.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

   // Which consumer check produced the fault (priority order top to bottom)
   typedef enum logic [1:0] {
      FSRC_NONE    = 2'd0,
      FSRC_BRANCH  = 2'd1,
      FSRC_ST_ADDR = 2'd2,
      FSRC_ST_DATA = 2'd3
   } fsrc_e;

   // Owner of the single write port in a cycle
   typedef enum logic [1:0] {
      WSRC_IDLE = 2'd0,
      WSRC_LOAD = 2'd1,
      WSRC_ALU  = 2'd2
   } wsrc_e;

endpackage

// File: rtl/dfr_write_sel.sv
module dfr_write_sel
   import dfr_pkg::*;
#(
   parameter int NREGS = 32,
   parameter int XLEN  = 64,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic             ld_we,
   input  logic [AW-1:0]    ld_dst,
   input  logic [XLEN-1:0]  ld_data,
   input  logic             ld_fault,
   input  logic             alu_we,
   input  logic [AW-1:0]    alu_dst,
   input  logic [XLEN-1:0]  alu_data,
   input  logic [AW-1:0]    alu_src_a,
   input  logic [AW-1:0]    alu_src_b,
   input  logic [NREGS-1:0] tags_q,
   output logic             wr_en,
   output logic [AW-1:0]    wr_dst,
   output logic [XLEN-1:0]  wr_data,
   output logic             wr_tag
);

   wsrc_e owner;
   logic  alu_src_poison;

   // Poison carried by the ALU result: either stored source tag
   assign alu_src_poison = tags_q[alu_src_a] | tags_q[alu_src_b];

   always_comb begin
      if (ld_we)       owner = WSRC_LOAD;
      else if (alu_we) owner = WSRC_ALU;
      else             owner = WSRC_IDLE;
   end

   always_comb begin
      wr_en   = 1'b0;
      wr_dst  = '0;
      wr_data = '0;
      wr_tag  = 1'b0;
      unique case (owner)
         WSRC_LOAD: begin
            wr_en   = 1'b1;
            wr_dst  = ld_dst;
            wr_data = ld_data;
            wr_tag  = ld_fault;
         end
         WSRC_ALU: begin
            wr_en   = 1'b1;
            wr_dst  = alu_dst;
            wr_data = alu_data;
            wr_tag  = alu_src_poison;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dfr_regstore.sv
module dfr_regstore #(
   parameter int NREGS    = 32,
   parameter int XLEN     = 64,
   parameter int NRD      = 2,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NREGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_dst,
   input  logic [XLEN-1:0]           wr_data,
   input  logic                      wr_tag,
   input  logic [NRD-1:0][AW-1:0]    rd_idx,
   output logic [NRD-1:0][XLEN-1:0]  rd_data,
   output logic [NRD-1:0]            rd_tag,
   output logic [NREGS-1:0]          tags_q_o,
   output logic [NREGS-1:0]          tags_fwd_o
);

   if (NREGS != (1 << AW)) begin : g_bad_depth
      $error("dfr_regstore: NREGS must be a power of two");
   end
   if (NRD < 1) begin : g_bad_ports
      $error("dfr_regstore: NRD must be at least 1");
   end
   if (XLEN < 1) begin : g_bad_width
      $error("dfr_regstore: XLEN must be positive");
   end

   logic [XLEN-1:0]  regs_q [NREGS];
   logic [NREGS-1:0] tags_q;
   logic             wr_ok;

   // Variant: register 0 hardwired or ordinary
   if (ZERO_REG) begin : g_zero_hard
      assign wr_ok = wr_en && (wr_dst != '0);
   end else begin : g_zero_plain
      assign wr_ok = wr_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREGS; r++) regs_q[r] <= '0;
         tags_q <= '0;
      end else if (wr_ok) begin
         regs_q[wr_dst] <= wr_data;
         tags_q[wr_dst] <= wr_tag;
      end
   end

   // Tags as seen by same-cycle consumers
   always_comb begin
      tags_fwd_o = tags_q;
      if (wr_ok) tags_fwd_o[wr_dst] = wr_tag;
   end
   assign tags_q_o = tags_q;

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic hit;
      assign hit        = wr_ok && (wr_dst == rd_idx[p]);
      assign rd_data[p] = hit ? wr_data : regs_q[rd_idx[p]];
      assign rd_tag[p]  = hit ? wr_tag  : tags_q[rd_idx[p]];
   end

   a_r1_reset_clean: assert property (@(posedge clk) !rst_n |=> tags_q == '0);

   if (ZERO_REG) begin : g_zero_chk
      a_r4_zero_stays_clean: assert property (@(posedge clk) disable iff (!rst_n)
         !tags_q[0] && (regs_q[0] == '0));
   end

   a_r9_tag_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(tags_q));

endmodule

// File: rtl/dfr_fault_detect.sv
module dfr_fault_detect
   import dfr_pkg::*;
#(
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NREGS-1:0] tags_fwd,
   input  logic             br_valid,
   input  logic [AW-1:0]    br_idx,
   input  logic             st_valid,
   input  logic [AW-1:0]    st_addr_idx,
   input  logic [AW-1:0]    st_data_idx,
   output logic             fault_valid,
   output logic [AW-1:0]    fault_idx
);

   fsrc_e         src;
   logic [AW-1:0] src_idx;

   always_comb begin
      if (br_valid && tags_fwd[br_idx])           src = FSRC_BRANCH;
      else if (st_valid && tags_fwd[st_addr_idx]) src = FSRC_ST_ADDR;
      else if (st_valid && tags_fwd[st_data_idx]) src = FSRC_ST_DATA;
      else                                        src = FSRC_NONE;
   end

   always_comb begin
      unique case (src)
         FSRC_BRANCH:  src_idx = br_idx;
         FSRC_ST_ADDR: src_idx = st_addr_idx;
         FSRC_ST_DATA: src_idx = st_data_idx;
         default:      src_idx = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_valid <= 1'b0;
         fault_idx   <= '0;
      end else begin
         fault_valid <= (src != FSRC_NONE);
         fault_idx   <= src_idx;
      end
   end

   a_r5_needs_consumer: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> $past(br_valid || st_valid));

   a_r6_quiet_without_check: assert property (@(posedge clk) disable iff (!rst_n)
      !(br_valid || st_valid) |=> !fault_valid && (fault_idx == '0));

endmodule

// File: rtl/deferred_fault_regfile.sv
module deferred_fault_regfile #(
   parameter int NREGS    = 32,
   parameter int XLEN     = 64,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NREGS),
   localparam int NRD     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   rd_a_idx,
   output logic [XLEN-1:0] rd_a_data,
   output logic            rd_a_tag,
   input  logic [AW-1:0]   rd_b_idx,
   output logic [XLEN-1:0] rd_b_data,
   output logic            rd_b_tag,
   input  logic            ld_we,
   input  logic [AW-1:0]   ld_dst,
   input  logic [XLEN-1:0] ld_data,
   input  logic            ld_fault,
   input  logic            alu_we,
   input  logic [AW-1:0]   alu_dst,
   input  logic [XLEN-1:0] alu_data,
   input  logic [AW-1:0]   alu_src_a,
   input  logic [AW-1:0]   alu_src_b,
   input  logic            br_valid,
   input  logic [AW-1:0]   br_idx,
   input  logic            st_valid,
   input  logic [AW-1:0]   st_addr_idx,
   input  logic [AW-1:0]   st_data_idx,
   output logic            fault_valid,
   output logic [AW-1:0]   fault_idx
);

   logic                     wr_en;
   logic [AW-1:0]            wr_dst;
   logic [XLEN-1:0]          wr_data;
   logic                     wr_tag;
   logic [NREGS-1:0]         tags_q;
   logic [NREGS-1:0]         tags_fwd;
   logic [NRD-1:0][AW-1:0]   rd_idx;
   logic [NRD-1:0][XLEN-1:0] rd_data;
   logic [NRD-1:0]           rd_tag;

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;
   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];
   assign rd_a_tag  = rd_tag[0];
   assign rd_b_tag  = rd_tag[1];

   dfr_write_sel #(.NREGS(NREGS), .XLEN(XLEN)) u_wsel (
      .ld_we     (ld_we),
      .ld_dst    (ld_dst),
      .ld_data   (ld_data),
      .ld_fault  (ld_fault),
      .alu_we    (alu_we),
      .alu_dst   (alu_dst),
      .alu_data  (alu_data),
      .alu_src_a (alu_src_a),
      .alu_src_b (alu_src_b),
      .tags_q    (tags_q),
      .wr_en     (wr_en),
      .wr_dst    (wr_dst),
      .wr_data   (wr_data),
      .wr_tag    (wr_tag)
   );

   dfr_regstore #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NRD), .ZERO_REG(ZERO_REG)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_dst     (wr_dst),
      .wr_data    (wr_data),
      .wr_tag     (wr_tag),
      .rd_idx     (rd_idx),
      .rd_data    (rd_data),
      .rd_tag     (rd_tag),
      .tags_q_o   (tags_q),
      .tags_fwd_o (tags_fwd)
   );

   dfr_fault_detect #(.NREGS(NREGS)) u_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .tags_fwd    (tags_fwd),
      .br_valid    (br_valid),
      .br_idx      (br_idx),
      .st_valid    (st_valid),
      .st_addr_idx (st_addr_idx),
      .st_data_idx (st_data_idx),
      .fault_valid (fault_valid),
      .fault_idx   (fault_idx)
   );

   a_r2_fault_load_marks: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we && ld_fault && (ld_dst != '0) |=> tags_q[$past(ld_dst)]);

   a_r3_clean_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we && !ld_fault && (ld_dst != '0) |=> !tags_q[$past(ld_dst)]);

   a_r3_alu_inherits: assert property (@(posedge clk) disable iff (!rst_n)
      alu_we && !ld_we && (alu_dst != '0) && (tags_q[alu_src_a] || tags_q[alu_src_b])
      |=> tags_q[$past(alu_dst)]);

   a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we && alu_we && (ld_dst != '0) |=> tags_q[$past(ld_dst)] == $past(ld_fault));

   a_r5_fault_is_poisoned: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> tags_q[fault_idx]);

endmodule

// File: tb/deferred_fault_regfile_test.sv
`timescale 1ns/1ps
module deferred_fault_regfile_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_a_idx = '0, rd_b_idx = '0;
   logic [63:0] rd_a_data, rd_b_data;
   logic        rd_a_tag, rd_b_tag;
   logic        ld_we = 1'b0, ld_fault = 1'b0;
   logic [4:0]  ld_dst = '0;
   logic [63:0] ld_data = '0;
   logic        alu_we = 1'b0;
   logic [4:0]  alu_dst = '0, alu_src_a = '0, alu_src_b = '0;
   logic [63:0] alu_data = '0;
   logic        br_valid = 1'b0, st_valid = 1'b0;
   logic [4:0]  br_idx = '0, st_addr_idx = '0, st_data_idx = '0;
   logic        fault_valid;
   logic [4:0]  fault_idx;

   always #2.5 clk = ~clk;

   deferred_fault_regfile uut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_tag(rd_a_tag),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_tag(rd_b_tag),
      .ld_we(ld_we), .ld_dst(ld_dst), .ld_data(ld_data), .ld_fault(ld_fault),
      .alu_we(alu_we), .alu_dst(alu_dst), .alu_data(alu_data),
      .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
      .br_valid(br_valid), .br_idx(br_idx),
      .st_valid(st_valid), .st_addr_idx(st_addr_idx), .st_data_idx(st_data_idx),
      .fault_valid(fault_valid), .fault_idx(fault_idx)
   );

   // Behavioural reference state
   logic [63:0] m_data [32];
   bit          m_tag  [32];
   bit          ef_valid;
   logic [4:0]  ef_idx;
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          finished = 0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic quiet();
      ld_we = 0; alu_we = 0; br_valid = 0; st_valid = 0; ld_fault = 0;
   endtask

   // Compare this cycle's outputs, then advance the model across the edge
   task automatic step(string req);
      bit          w_en, w_tag, hit;
      logic [4:0]  w_dst;
      logic [63:0] w_dat;
      bit          tb, ta, td;
      #1;
      w_en = 0; w_tag = 0; w_dst = 0; w_dat = 0;
      if (ld_we) begin
         w_en = 1; w_dst = ld_dst; w_dat = ld_data; w_tag = ld_fault;
      end else if (alu_we) begin
         w_en = 1; w_dst = alu_dst; w_dat = alu_data;
         w_tag = m_tag[alu_src_a] | m_tag[alu_src_b];
      end
      if (w_dst == 0) w_en = 0;
      hit = w_en && (w_dst == rd_a_idx);
      chk(req, "rd_a_data", rd_a_data, hit ? w_dat : m_data[rd_a_idx]);
      chk(req, "rd_a_tag",  64'(rd_a_tag), 64'(hit ? w_tag : m_tag[rd_a_idx]));
      hit = w_en && (w_dst == rd_b_idx);
      chk(req, "rd_b_data", rd_b_data, hit ? w_dat : m_data[rd_b_idx]);
      chk(req, "rd_b_tag",  64'(rd_b_tag), 64'(hit ? w_tag : m_tag[rd_b_idx]));
      chk(req, "fault_valid", 64'(fault_valid), 64'(ef_valid));
      chk(req, "fault_idx",   64'(fault_idx),   64'(ef_idx));
      tb = (w_en && w_dst == br_idx)      ? w_tag : m_tag[br_idx];
      ta = (w_en && w_dst == st_addr_idx) ? w_tag : m_tag[st_addr_idx];
      td = (w_en && w_dst == st_data_idx) ? w_tag : m_tag[st_data_idx];
      ef_valid = 0; ef_idx = 0;
      if (br_valid && tb)      begin ef_valid = 1; ef_idx = br_idx; end
      else if (st_valid && ta) begin ef_valid = 1; ef_idx = st_addr_idx; end
      else if (st_valid && td) begin ef_valid = 1; ef_idx = st_data_idx; end
      if (w_en) begin m_data[w_dst] = w_dat; m_tag[w_dst] = w_tag; end
      @(negedge clk);
   endtask

   task automatic do_load(logic [4:0] d, logic [63:0] v, bit f, string req);
      quiet(); ld_we = 1; ld_dst = d; ld_data = v; ld_fault = f; step(req);
   endtask

   task automatic do_alu(logic [4:0] d, logic [4:0] a, logic [4:0] b, logic [63:0] v, string req);
      quiet(); alu_we = 1; alu_dst = d; alu_src_a = a; alu_src_b = b; alu_data = v; step(req);
   endtask

   task automatic do_read(logic [4:0] a, logic [4:0] b, string req);
      quiet(); rd_a_idx = a; rd_b_idx = b; step(req);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin m_data[i] = '0; m_tag[i] = 0; end
      ef_valid = 0; ef_idx = 0;
      @(negedge clk);
      step("R1");                       // outputs during reset
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) do_read(5'(2*i), 5'(2*i+1), "R1");

      // Faulting and clean loads, ALU propagation
      do_load(5, 64'hDEAD_0005, 1, "R2");
      do_load(6, 64'h0000_0006, 0, "R3");
      do_alu(7, 5, 6, 64'h77, "R3");
      do_alu(8, 6, 6, 64'h88, "R3");
      do_alu(10, 6, 7, 64'hAA, "R3");
      do_read(5, 6, "R2");
      do_read(7, 8, "R3");
      do_read(10, 0, "R6");

      // Tag survives a long idle gap, then a branch consumes it
      for (int i = 0; i < 60; i++) do_read(7, 5, "R9");
      quiet(); br_valid = 1; br_idx = 7; step("R9");
      quiet(); step("R5");

      // Clean consumers: no fault
      quiet(); st_valid = 1; st_addr_idx = 6; st_data_idx = 8; step("R6");
      quiet(); br_valid = 1; br_idx = 8; step("R6");
      // Store data poisoned
      quiet(); st_valid = 1; st_addr_idx = 6; st_data_idx = 7; step("R5");
      // Priority: branch over store address over store data
      quiet(); br_valid = 1; br_idx = 5; st_valid = 1; st_addr_idx = 7; st_data_idx = 10; step("R5");
      quiet(); st_valid = 1; st_addr_idx = 7; st_data_idx = 10; step("R5");
      quiet(); step("R5");
      quiet(); step("R6");

      // Register 0 discards writes
      do_load(0, 64'hFFFF, 1, "R4");
      do_alu(0, 5, 7, 64'h1234, "R4");
      quiet(); br_valid = 1; br_idx = 0; st_valid = 1; st_addr_idx = 0; st_data_idx = 0;
      rd_a_idx = 0; rd_b_idx = 0; step("R4");
      do_read(0, 0, "R4");

      // Same-cycle write and read/consume
      quiet(); ld_we = 1; ld_dst = 9; ld_data = 64'h9999; ld_fault = 1;
      rd_a_idx = 9; rd_b_idx = 9; br_valid = 1; br_idx = 9; step("R7");
      quiet(); alu_we = 1; alu_dst = 9; alu_src_a = 6; alu_src_b = 8; alu_data = 64'h4242;
      rd_a_idx = 9; st_valid = 1; st_addr_idx = 9; st_data_idx = 9; step("R7");
      do_read(9, 9, "R7");

      // Load and ALU collide
      quiet(); ld_we = 1; ld_dst = 11; ld_data = 64'hB0B0; ld_fault = 1;
      alu_we = 1; alu_dst = 12; alu_src_a = 6; alu_src_b = 6; alu_data = 64'hC0C0; step("R8");
      do_read(11, 12, "R8");
      quiet(); ld_we = 1; ld_dst = 13; ld_data = 64'h1313; ld_fault = 0;
      alu_we = 1; alu_dst = 13; alu_src_a = 5; alu_src_b = 5; alu_data = 64'h3131; step("R8");
      do_read(13, 11, "R8");

      // Clean overwrite clears tag
      do_alu(7, 6, 8, 64'h7070, "R3");
      do_load(5, 64'h5050, 0, "R3");
      quiet(); br_valid = 1; br_idx = 7; st_valid = 1; st_addr_idx = 5; st_data_idx = 5; step("R3");
      quiet(); step("R6");

      // Random traffic on a small register window
      for (int i = 0; i < 3000; i++) begin
         quiet();
         ld_we    = ($urandom_range(0, 2) == 0);
         ld_dst   = 5'($urandom_range(0, 7));
         ld_data  = {$urandom, $urandom};
         ld_fault = ($urandom_range(0, 3) == 0);
         alu_we   = ($urandom_range(0, 1) == 0);
         alu_dst  = 5'($urandom_range(0, 7));
         alu_src_a = 5'($urandom_range(0, 7));
         alu_src_b = 5'($urandom_range(0, 7));
         alu_data = {$urandom, $urandom};
         br_valid = ($urandom_range(0, 3) == 0);
         br_idx   = 5'($urandom_range(0, 7));
         st_valid = ($urandom_range(0, 3) == 0);
         st_addr_idx = 5'($urandom_range(0, 7));
         st_data_idx = 5'($urandom_range(0, 7));
         rd_a_idx = 5'($urandom_range(0, 7));
         rd_b_idx = 5'($urandom_range(0, 31));
         step("R7 R3 R5 random");
      end
      quiet(); step("R6");

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule